// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block is a signed fixed-point multiply-accumulate datapath. Every cycle it accepts two DW-bit two's-complement operands, forms their exact 2·DW-bit product, and registers that product together with the requested operation. In the next cycle the product is first scaled by an arithmetic right shift. It is then added to the accumulator, subtracted from it, or loaded into it. The accumulator is GUARD bits wider than the product, so long runs of sums stay exact.

When a sum leaves the accumulator's signed range, the unit either clamps the result to the nearest bound or lets it wrap, depending on a per-operation saturation enable. A sticky overflow flag records the event until software-side logic pulses a clear. Sign, zero and carry flags follow the accumulator.

A store request copies the low 2·DW bits of the accumulator onto a DW-bit result port. In narrow mode only the upper half is sent. In wide mode the upper half is sent first and the lower half in the following cycle.

Top module: `sat_mac`

## Requirements
- R1: The product of `a_i` and `b_i` (signed) is kept at the full 2·DW bits, and an operation's effect on the accumulator is visible two clock edges after its operands are presented: one edge for the product register and one for the accumulator.
- R2: `op_i` encodes 00 = hold (accumulator and carry unchanged), 01 = add product, 10 = subtract product, 11 = load product (sign-extended).
- R3: The accumulator is 2·DW+GUARD bits wide. Sums that exceed the 2·DW-bit range but stay inside that width raise no overflow and lose no bits.
- R4: Before it is used, the product is arithmetically right-shifted by `shift_i` (0 to 2·DW-1). The shift amount travels with its operands.
- R5: With `sat_en_i` = 1, an add or subtract whose exact result exceeds 2^(AW-1)-1 leaves that value in the accumulator. A result below -2^(AW-1) leaves -2^(AW-1).
- R6: With `sat_en_i` = 0, an overflowing add or subtract leaves the exact result modulo 2^AW in the accumulator.
- R7: `ovf_o` goes high after any add or subtract that overflows, whatever the saturation setting. It stays high until `clr_ovf_i` is high in a cycle with no new overflow. A new overflow in the same cycle as a clear leaves it high.
- R8: `carry_o` is the carry out of the AW-bit unsigned addition of the accumulator and the operand (the two's-complement negation of the scaled product for subtract). It is cleared by a load and held by a hold.
- R9: `sign_o` is the accumulator's top bit, and `zero_o` is high exactly when the accumulator is zero.
- R10: A store request in a cycle produces, one edge later, `res_valid_o` = 1 and `res_low_o` = 0, with `res_word_o` = accumulator bits [2·DW-1:DW] as they stood in the request cycle.
- R11: If `wide_i` was high with the store, the next cycle carries `res_valid_o` = 1, `res_low_o` = 1 and bits [DW-1:0] of the same snapshot. A store request in the cycle the low word is pending is ignored.
- R12: After reset the accumulator is zero (`zero_o` = 1, `sign_o` = 0), `carry_o`, `ovf_o` and `res_valid_o` are 0, and the pipeline holds a hold operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 2 | Operation code (R2) |
| a_i | input | DW | Signed operand |
| b_i | input | DW | Signed operand |
| shift_i | input | clog2(2·DW) | Right-shift amount applied to the product |
| sat_en_i | input | 1 | 1 = clamp on overflow, 0 = wrap |
| clr_ovf_i | input | 1 | Clears the sticky overflow flag |
| store_i | input | 1 | Request to send the accumulator on the result port |
| wide_i | input | 1 | 1 = send both halves, 0 = upper half only |
| res_word_o | output | DW | Result word |
| res_valid_o | output | 1 | Result word is valid |
| res_low_o | output | 1 | Result word is the lower half |
| sign_o | output | 1 | Accumulator sign |
| zero_o | output | 1 | Accumulator is zero |
| carry_o | output | 1 | Carry from the last add or subtract |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
Two events can coincide in a single cycle. The first is a clear of the overflow flag arriving while an add that overflows is being accumulated. The second is a store snapshot taken in the same edge that the accumulator is rewritten.

The bench drives long runs of maximum-magnitude products into the guard bits until the range is crossed. During those runs it holds the clear high on alternate cycles and requests stores every cycle, in both saturating and wrapping modes. A behavioural model using plain integers predicts the flag and result words on every clock. That model settles each collision explicitly: a new overflow beats the clear, and a snapshot takes the value from before the update.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'b00,
    OP_ADD  = 2'b01,
    OP_SUB  = 2'b10,
    OP_LOAD = 2'b11
  } mac_op_e;
endpackage

// File: rtl/mac_mult_stage.sv
// Multiplier plus the pipeline register in front of the accumulator.
module mac_mult_stage
  import mac_pkg::*;
#(
  parameter int DW = 16,
  localparam int PW = 2 * DW,
  localparam int SHW = $clog2(PW)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [DW-1:0] a_i,
  input  logic signed [DW-1:0] b_i,
  input  mac_op_e              op_i,
  input  logic [SHW-1:0]       shift_i,
  input  logic                 sat_i,
  output logic [PW-1:0]        prod_o,
  output mac_op_e              op_o,
  output logic [SHW-1:0]       shift_o,
  output logic                 sat_o
);
  logic signed [PW-1:0] prod_d;

  always_comb begin
    prod_d = PW'(a_i) * PW'(b_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_o  <= '0;
      op_o    <= OP_HOLD;
      shift_o <= '0;
      sat_o   <= 1'b0;
    end else begin
      prod_o  <= prod_d;
      op_o    <= op_i;
      shift_o <= shift_i;
      sat_o   <= sat_i;
    end
  end
endmodule

// File: rtl/mac_accum.sv
// Scaling, add/subtract/load, saturation and flags.
module mac_accum
  import mac_pkg::*;
#(
  parameter int DW = 16,
  parameter int GUARD = 6,
  localparam int PW = 2 * DW,
  localparam int AW = PW + GUARD,
  localparam int SHW = $clog2(PW)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [PW-1:0]  prod_i,
  input  mac_op_e        op_i,
  input  logic [SHW-1:0] shift_i,
  input  logic           sat_i,
  input  logic           clr_ovf_i,
  output logic [AW-1:0]  acc_o,
  output logic           carry_o,
  output logic           ovf_o
);
  localparam logic [AW-1:0] ONE     = AW'(1);
  localparam logic [AW-1:0] SAT_MAX = {1'b0, {(AW-1){1'b1}}};
  localparam logic [AW-1:0] SAT_MIN = {1'b1, {(AW-1){1'b0}}};

  logic [AW-1:0] acc_q, acc_d;
  logic          carry_q, carry_d;
  logic          ovf_q, ovf_d;
  logic [PW-1:0] scaled;
  logic [AW-1:0] ext, opnd, sum;
  logic          carry_s;
  logic          arith, ovf_evt;

  always_comb begin
    scaled  = $signed(prod_i) >>> shift_i;
    ext     = {{GUARD{scaled[PW-1]}}, scaled};
    opnd    = (op_i == OP_SUB) ? (~ext + ONE) : ext;
    {carry_s, sum} = {1'b0, acc_q} + {1'b0, opnd};
    arith   = (op_i == OP_ADD) || (op_i == OP_SUB);
    ovf_evt = arith && (acc_q[AW-1] == opnd[AW-1]) && (sum[AW-1] != acc_q[AW-1]);
  end

  always_comb begin
    acc_d   = acc_q;
    carry_d = carry_q;
    unique case (op_i)
      OP_HOLD: begin
        acc_d   = acc_q;
        carry_d = carry_q;
      end
      OP_ADD, OP_SUB: begin
        carry_d = carry_s;
        if (ovf_evt && sat_i) acc_d = acc_q[AW-1] ? SAT_MIN : SAT_MAX;
        else                  acc_d = sum;
      end
      OP_LOAD: begin
        acc_d   = ext;
        carry_d = 1'b0;
      end
      default: begin
        acc_d   = acc_q;
        carry_d = carry_q;
      end
    endcase
    ovf_d = (ovf_q && !clr_ovf_i) || ovf_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      carry_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      acc_q   <= acc_d;
      carry_q <= carry_d;
      ovf_q   <= ovf_d;
    end
  end

  assign acc_o   = acc_q;
  assign carry_o = carry_q;
  assign ovf_o   = ovf_q;

  p_hold_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_HOLD) |=> $stable(acc_q));
  p_sat_clamp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && sat_i) |=> (acc_q == SAT_MAX || acc_q == SAT_MIN));
  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !clr_ovf_i) |=> ovf_q);
  p_load_carry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_LOAD) |=> !carry_q);
endmodule

// File: rtl/mac_out_port.sv
// Sends the accumulator on a DW-bit port as one or two words.
module mac_out_port #(
  parameter int DW = 16,
  localparam int PW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] acc_word_i,
  input  logic          store_i,
  input  logic          wide_i,
  output logic [DW-1:0] word_o,
  output logic          valid_o,
  output logic          low_o
);
  logic [DW-1:0] word_q, word_d, snap_q, snap_d;
  logic          valid_q, valid_d, low_q, low_d, pend_q, pend_d;

  always_comb begin
    word_d  = word_q;
    snap_d  = snap_q;
    valid_d = 1'b0;
    low_d   = 1'b0;
    pend_d  = 1'b0;
    if (pend_q) begin
      word_d  = snap_q;
      valid_d = 1'b1;
      low_d   = 1'b1;
    end else if (store_i) begin
      word_d  = acc_word_i[PW-1:DW];
      snap_d  = acc_word_i[DW-1:0];
      valid_d = 1'b1;
      pend_d  = wide_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      snap_q  <= '0;
      valid_q <= 1'b0;
      low_q   <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      word_q  <= word_d;
      snap_q  <= snap_d;
      valid_q <= valid_d;
      low_q   <= low_d;
      pend_q  <= pend_d;
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;
  assign low_o   = low_q;

  p_low_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |=> (valid_q && low_q));
  p_single_pending_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |=> !pend_q);
  p_high_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (store_i && !pend_q) |=> (valid_q && !low_q));
endmodule

// File: rtl/sat_mac.sv
module sat_mac
  import mac_pkg::*;
#(
  parameter int DW = 16,
  parameter int GUARD = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0]                 op_i,
  input  logic [DW-1:0]              a_i,
  input  logic [DW-1:0]              b_i,
  input  logic [$clog2(2*DW)-1:0]    shift_i,
  input  logic                       sat_en_i,
  input  logic                       clr_ovf_i,
  input  logic                       store_i,
  input  logic                       wide_i,
  output logic [DW-1:0]              res_word_o,
  output logic                       res_valid_o,
  output logic                       res_low_o,
  output logic                       sign_o,
  output logic                       zero_o,
  output logic                       carry_o,
  output logic                       ovf_o
);
  localparam int PW  = 2 * DW;
  localparam int AW  = PW + GUARD;
  localparam int SHW = $clog2(PW);

  logic [PW-1:0]  prod_q;
  mac_op_e        op_q;
  logic [SHW-1:0] shift_q;
  logic           sat_q;
  logic [AW-1:0]  acc;

  mac_mult_stage #(.DW(DW)) u_mult (
    .clk(clk), .rst_n(rst_n),
    .a_i(a_i), .b_i(b_i), .op_i(mac_op_e'(op_i)),
    .shift_i(shift_i), .sat_i(sat_en_i),
    .prod_o(prod_q), .op_o(op_q), .shift_o(shift_q), .sat_o(sat_q)
  );

  mac_accum #(.DW(DW), .GUARD(GUARD)) u_acc (
    .clk(clk), .rst_n(rst_n),
    .prod_i(prod_q), .op_i(op_q), .shift_i(shift_q), .sat_i(sat_q),
    .clr_ovf_i(clr_ovf_i),
    .acc_o(acc), .carry_o(carry_o), .ovf_o(ovf_o)
  );

  mac_out_port #(.DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n),
    .acc_word_i(acc[PW-1:0]), .store_i(store_i), .wide_i(wide_i),
    .word_o(res_word_o), .valid_o(res_valid_o), .low_o(res_low_o)
  );

  assign sign_o = acc[AW-1];
  assign zero_o = ~|acc;
endmodule

// File: tb/tb_sat_mac.sv
`timescale 1ns/1ps
module tb_sat_mac;
  localparam int DW = 16;
  localparam int GUARD = 6;
  localparam int AW = 2 * DW + GUARD;
  localparam longint AM   = (64'sd1 <<< AW) - 1;
  localparam longint MAXV = (64'sd1 <<< (AW - 1)) - 1;
  localparam longint MINV = -(64'sd1 <<< (AW - 1));
  localparam longint WM   = (64'sd1 <<< DW) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] op;
  logic signed [DW-1:0] a, b;
  logic [4:0] sh;
  logic sat, clr, store, wide;
  logic [DW-1:0] res_word;
  logic res_valid, res_low, sign, zero, carry, ovf;

  always #4 clk = ~clk;

  sat_mac #(.DW(DW), .GUARD(GUARD)) dut (
    .clk(clk), .rst_n(rst_n), .op_i(op), .a_i(a), .b_i(b), .shift_i(sh),
    .sat_en_i(sat), .clr_ovf_i(clr), .store_i(store), .wide_i(wide),
    .res_word_o(res_word), .res_valid_o(res_valid), .res_low_o(res_low),
    .sign_o(sign), .zero_o(zero), .carry_o(carry), .ovf_o(ovf)
  );

  typedef struct { longint p; int op; int sh; bit sat; } ent_t;
  ent_t pq[$];
  longint acc_m, word_m, snap_m;
  bit carry_m, ovf_m, v_m, low_m, pend_m;
  int checks = 0, errors = 0;
  string ph = "R12";

  function automatic longint wrap(longint x);
    longint lo;
    lo = x & AM;
    if (lo > MAXV) lo = lo - (64'sd1 <<< AW);
    return lo;
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s [%s] act=%0h exp=%0h", tag, ph, act, exp);
    end
  endtask

  task automatic model_update();
    ent_t e, n;
    longint sc, opnd, sum;
    bit evt;
    if (pend_m) begin
      v_m = 1; low_m = 1; word_m = snap_m; pend_m = 0;
    end else if (store) begin
      v_m = 1; low_m = 0; word_m = (acc_m >>> DW) & WM;
      snap_m = acc_m & WM; pend_m = wide;
    end else begin
      v_m = 0; low_m = 0;
    end
    e = pq.pop_front();
    evt = 0;
    sc = e.p >>> e.sh;
    if (e.op == 1 || e.op == 2) begin
      opnd = (e.op == 2) ? -sc : sc;
      sum = acc_m + opnd;
      carry_m = (((acc_m & AM) + (opnd & AM)) >> AW) & 1;
      if (sum > MAXV || sum < MINV) begin
        evt = 1;
        acc_m = e.sat ? ((sum > MAXV) ? MAXV : MINV) : wrap(sum);
      end else acc_m = sum;
    end else if (e.op == 3) begin
      acc_m = sc; carry_m = 0;
    end
    ovf_m = (ovf_m && !clr) || evt;
    n.p = longint'(a) * longint'(b);
    n.op = int'(op); n.sh = int'(sh); n.sat = sat;
    pq.push_back(n);
  endtask

  task automatic compare();
    chk(res_valid == v_m, "R10 valid", res_valid, v_m);
    if (v_m) begin
      chk(res_low == low_m, "R11 low", res_low, low_m);
      chk(res_word == DW'(word_m), low_m ? "R11 word" : "R10 word", res_word, word_m);
    end
    chk(sign == (acc_m < 0), "R9 sign", sign, acc_m < 0);
    chk(zero == (acc_m == 0), "R9 zero", zero, acc_m == 0);
    chk(carry == carry_m, "R8 carry", carry, carry_m);
    chk(ovf == ovf_m, "R7 ovf", ovf, ovf_m);
  endtask

  task automatic cyc(int o, int x, int y, int s, bit st, bit c, bit str, bit w);
    op = 2'(o); a = DW'(x); b = DW'(y); sh = 5'(s);
    sat = st; clr = c; store = str; wide = w;
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare();
  endtask

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog [%s] act=0 exp=1", ph);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    ent_t h;
    h.p = 0; h.op = 0; h.sh = 0; h.sat = 0;
    pq.push_back(h);
    acc_m = 0; carry_m = 0; ovf_m = 0; v_m = 0; low_m = 0; pend_m = 0;
    word_m = 0; snap_m = 0;
    rst_n = 0; op = 0; a = 0; b = 0; sh = 0; sat = 0; clr = 0; store = 0; wide = 0;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(res_valid == 0, "R12 valid", res_valid, 0);
    chk(zero == 1, "R12 zero", zero, 1);
    chk(sign == 0, "R12 sign", sign, 0);
    chk(carry == 0 && ovf == 0, "R12 flags", {carry, ovf}, 0);
    rst_n = 1;

    ph = "R1 load latency";
    cyc(3, 3, -5, 0, 1, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 0, 1, 1);   // store sees pre-update value
    cyc(0, 0, 0, 0, 1, 0, 1, 1);
    cyc(0, 0, 0, 0, 1, 0, 1, 0);
    ph = "R2 add sub hold";
    cyc(1, 1234, 567, 0, 1, 0, 0, 0);
    cyc(2, -300, 77, 0, 1, 0, 1, 1);
    cyc(2, 32767, 32767, 0, 1, 0, 0, 0);
    cyc(0, 999, 999, 0, 1, 0, 1, 1);
    cyc(1, -1, 1, 0, 1, 0, 1, 0);
    cyc(0, 0, 0, 0, 1, 0, 1, 1);
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
    ph = "R4 shift";
    cyc(3, 1000, 1000, 4, 1, 0, 0, 0);
    cyc(1, -32768, 32767, 31, 1, 0, 1, 1);
    cyc(2, 12345, -321, 7, 1, 0, 1, 1);
    cyc(1, -7, 3, 1, 1, 0, 1, 1);
    cyc(0, 0, 0, 0, 1, 0, 1, 1);
    cyc(0, 0, 0, 0, 1, 0, 1, 1);
    ph = "R3 guard growth";
    cyc(3, -32768, -32768, 0, 1, 0, 0, 0);
    for (int i = 0; i < 100; i++) cyc(1, -32768, -32768, 0, 1, 0, (i % 7) == 0, 1);
    ph = "R5 positive clamp";
    for (int i = 0; i < 40; i++) cyc(1, -32768, -32768, 0, 1, 0, 1, i[0]);
    ph = "R7 clear vs overflow";
    for (int i = 0; i < 12; i++) cyc(1, -32768, -32768, 0, 1, i[0], 1, 1);
    cyc(0, 0, 0, 0, 1, 1, 0, 0);
    cyc(0, 0, 0, 0, 1, 0, 0, 0);
    ph = "R5 negative clamp";
    cyc(3, 0, 0, 0, 1, 0, 0, 0);
    for (int i = 0; i < 135; i++) cyc(2, -32768, -32768, 0, 1, (i % 5) == 0, i[1], 1);
    cyc(0, 0, 0, 0, 1, 1, 1, 1);
    cyc(0, 0, 0, 0, 1, 0, 0, 0);
    ph = "R6 wraparound";
    cyc(3, -32768, -32768, 0, 0, 0, 0, 0);
    for (int i = 0; i < 135; i++) cyc(1, -32768, -32768, 0, 0, 0, (i % 3) == 0, 1);
    cyc(2, 5, 5, 0, 0, 0, 1, 1);
    ph = "R8 carry";
    cyc(3, 100, 100, 0, 1, 1, 0, 0);
    cyc(1, -1, 1, 0, 1, 0, 0, 0);
    cyc(2, 1, 1, 0, 1, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 0, 0, 0);
    cyc(3, 0, 0, 0, 1, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 0, 1, 1);
    cyc(0, 0, 0, 0, 1, 0, 1, 0);
    cyc(0, 0, 0, 0, 1, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 0, 0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule